// File: doc/BRIEF.md
# Two-Sided Channelled Message Mailbox

The mailbox lets two processors pass 32-bit words to each other through eight one-way channels. Each channel queues up to four words. Both processors reach the block through their own register port. A port is a simple bus that completes in a single cycle. Read data is a combinational function of the address. Any side effect of an access (a push, a pop or a status clear) takes place at the clock edge that ends the cycle.

Every channel has one direction, held in control words that both sides share. Each side sees the direction flags from its own point of view. A side that writes the channel's data register enqueues a word for the other side. When that word arrives, the receiver's interrupt status for the channel goes high.

The receiver cannot clear that status bit until it has drained the channel. Each side can also read the other side's status and enable registers. A sender therefore knows that its message has been consumed once the receiver's receive bit for the channel reads 0. Each side has one interrupt line, which is high when any of that side's enabled status bits is set.

Top module: `dual_mailbox`

## Requirements
- R1: After reset every queue is empty, and all control, enable and status registers read 0. Both interrupt lines are low.
- R2: Channel n's flags live in the control word at byte offset 4*(n/4). The receive flag is at bit 8*(n%4) and the transmit flag is at bit 8*(n%4)+4. Both sides share this storage, with the flags mirrored: when one side's view shows transmit, the other side's view shows receive. A channel carries traffic only when exactly one of the two flags is set.
- R3: The data register of channel n is at 0x180+4n. A sender's write enqueues a word, and a receiver's read returns and removes the oldest word. The queue is first-in first-out and holds 4 words. A receiver's read of an empty queue returns 0.
- R4: The register at 0x140+4n gives the queued word count (0 to 4) in bits 2:0. Bit 0 of the register at 0x100+4n reads 1 when the queue is full. Both sides can read these registers.
- R5: A write to a full queue is dropped, and the stored words and the count stay as they were.
- R6: Data-register accesses that do not match the channel's direction change nothing. This covers a write by the receiver, a read by the sender (which returns 0), and any access on a channel that has no valid direction.
- R7: When a word is enqueued, the receiving side's own status bit 2n (own status at 0x070) becomes 1.
- R8: Writing 1 to a bit of the own status register clears that bit. A receive bit (2n) stays 1 while its queue is not empty.
- R9: Offset 0x050 reads the other side's status and offset 0x040 reads the other side's enable register. Writes to these two offsets have no effect.
- R10: Each time the receiver removes a word, the sending side's status bit 2n+1 becomes 1.
- R11: The own enable register is at 0x060. A side's interrupt line is high exactly when some bit is set in both its status and its enable register.
- R12: If both sides write the same control word in the same cycle, the write from side A takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 9 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 9 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench attempts to clear a receive bit while words are still queued. A design that cleared it anyway would report a message as acknowledged before it was read.

It fills a queue and then writes once more. A queue that overwrote or wrapped would return a fifth word or a wrong count. It also makes wrong-direction accesses: a receiver write, a sender read, and traffic on a channel with no direction. A design that honoured these would corrupt the queue or lose a word silently.

Finally, the bench writes the same control word from both sides at once. It also reads the mirrored flags and the remote status. A design that mixed up the two views would show the wrong side as the sender.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MB_NCH   = 8;
    localparam int MB_DEPTH = 4;
    localparam int MB_DW    = 32;
    localparam int MB_AW    = 9;
    localparam int MB_WW    = MB_AW - 2;

    // word indices (byte offset / 4)
    localparam logic [MB_WW-1:0] W_CTRL_END = 7'd4;
    localparam logic [MB_WW-1:0] W_REM_EN   = 7'd16;
    localparam logic [MB_WW-1:0] W_REM_ST   = 7'd20;
    localparam logic [MB_WW-1:0] W_OWN_EN   = 7'd24;
    localparam logic [MB_WW-1:0] W_OWN_ST   = 7'd28;
    localparam logic [MB_WW-1:0] W_FULL     = 7'd64;
    localparam logic [MB_WW-1:0] W_COUNT    = 7'd80;
    localparam logic [MB_WW-1:0] W_DATA     = 7'd96;
    localparam logic [MB_WW-1:0] W_BANK     = 7'd16;

    typedef enum logic [3:0] {
        RK_NONE, RK_CTRL, RK_REM_EN, RK_REM_ST, RK_OWN_EN,
        RK_OWN_ST, RK_FULL, RK_COUNT, RK_DATA
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    // direction flags as seen from side A
    typedef struct packed {
        logic tx_a;
        logic rx_a;
    } chan_dir_t;

    function automatic reg_sel_t decode_addr(input logic [MB_AW-1:0] addr);
        reg_sel_t         r;
        logic [MB_WW-1:0] w;
        w      = addr[MB_AW-1:2];
        r.kind = RK_NONE;
        r.idx  = w[3:0];
        if (w < W_CTRL_END)                              r.kind = RK_CTRL;
        else if (w == W_REM_EN)                          r.kind = RK_REM_EN;
        else if (w == W_REM_ST)                          r.kind = RK_REM_ST;
        else if (w == W_OWN_EN)                          r.kind = RK_OWN_EN;
        else if (w == W_OWN_ST)                          r.kind = RK_OWN_ST;
        else if (w >= W_FULL  && w < W_FULL  + W_BANK)  r.kind = RK_FULL;
        else if (w >= W_COUNT && w < W_COUNT + W_BANK)  r.kind = RK_COUNT;
        else if (w >= W_DATA  && w < W_DATA  + W_BANK)  r.kind = RK_DATA;
        return r;
    endfunction

    function automatic int rx_bit(input int n);
        return 8 * (n % 4);
    endfunction

    function automatic int tx_bit(input int n);
        return 8 * (n % 4) + 4;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                din,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          accept, take;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (take) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));                                          // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);                                      // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));   // R3

endmodule

// File: rtl/mbox_irq_side.sv
module mbox_irq_side #(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr,
    input  logic               st_clr,
    input  logic [DW-1:0]      wdata,
    input  logic [NCH-1:0]     set_rx,
    input  logic [NCH-1:0]     set_tx,
    input  logic [NCH-1:0]     rx_busy,
    output logic [2*NCH-1:0]   en,
    output logic [2*NCH-1:0]   stat,
    output logic               irq
);
    localparam int SW = 2 * NCH;

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            stat <= '0;
        end else begin
            if (en_wr) en <= wdata[SW-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (set_rx[n])
                    stat[2*n] <= 1'b1;
                else if (st_clr && wdata[2*n] && !rx_busy[n])
                    stat[2*n] <= 1'b0;
                if (set_tx[n])
                    stat[2*n+1] <= 1'b1;
                else if (st_clr && wdata[2*n+1])
                    stat[2*n+1] <= 1'b0;
            end
        end
    end

    assign irq = |(stat & en);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);                                          // R11

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        AST_RX_STICKY: assert property (@(posedge clk) disable iff (rst)
            (stat[2*n] && rx_busy[n]) |=> stat[2*n]);                  // R8
    end

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbox_pkg::*;
#(
    parameter int NCH   = MB_NCH,
    parameter int DEPTH = MB_DEPTH,
    parameter int DW    = MB_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MB_AW-1:0] a_addr,
    input  logic [DW-1:0]    a_wdata,
    input  logic             a_wr,
    input  logic             a_rd,
    output logic [DW-1:0]    a_rdata,
    output logic             a_irq,
    input  logic [MB_AW-1:0] b_addr,
    input  logic [DW-1:0]    b_wdata,
    input  logic             b_wr,
    input  logic             b_rd,
    output logic [DW-1:0]    b_rdata,
    output logic             b_irq
);
    localparam int SW  = 2 * NCH;
    localparam int CTW = (NCH + 3) / 4;
    localparam int CW  = $clog2(DEPTH + 1);

    logic [MB_AW-1:0] p_addr  [2];
    logic [DW-1:0]    p_wdata [2];
    logic             p_wr    [2];
    logic             p_rd    [2];
    logic [DW-1:0]    p_rdata [2];
    reg_sel_t         sel     [2];

    chan_dir_t        dir_q   [NCH];
    logic [NCH-1:0]   a2b, b2a;
    logic [NCH-1:0]   send_ok [2];
    logic [NCH-1:0]   recv_ok [2];

    logic [NCH-1:0]   push, pop, full, empty;
    logic [DW-1:0]    head    [NCH];
    logic [DW-1:0]    din     [NCH];
    logic [CW-1:0]    count   [NCH];

    logic [NCH-1:0]   set_rx  [2];
    logic [NCH-1:0]   set_tx  [2];
    logic [SW-1:0]    en      [2];
    logic [SW-1:0]    stat    [2];
    logic             irq     [2];

    always_comb begin
        p_addr[0] = a_addr;  p_wdata[0] = a_wdata;  p_wr[0] = a_wr;  p_rd[0] = a_rd;
        p_addr[1] = b_addr;  p_wdata[1] = b_wdata;  p_wr[1] = b_wr;  p_rd[1] = b_rd;
        for (int s = 0; s < 2; s++) sel[s] = decode_addr(p_addr[s]);
    end

    // ---------------- direction control ----------------
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            a2b[n] = dir_q[n].tx_a && !dir_q[n].rx_a;
            b2a[n] = dir_q[n].rx_a && !dir_q[n].tx_a;
        end
        send_ok[0] = a2b;  recv_ok[0] = b2a;
        send_ok[1] = b2a;  recv_ok[1] = a2b;
    end

    always_ff @(posedge clk) begin
        for (int n = 0; n < NCH; n++) begin
            if (rst) begin
                dir_q[n] <= '0;
            end else if (p_wr[0] && sel[0].kind == RK_CTRL && sel[0].idx == 4'(n / 4)) begin
                dir_q[n].tx_a <= p_wdata[0][tx_bit(n)];
                dir_q[n].rx_a <= p_wdata[0][rx_bit(n)];
            end else if (p_wr[1] && sel[1].kind == RK_CTRL && sel[1].idx == 4'(n / 4)) begin
                dir_q[n].rx_a <= p_wdata[1][tx_bit(n)];
                dir_q[n].tx_a <= p_wdata[1][rx_bit(n)];
            end
        end
    end

    // ---------------- channel queues ----------------
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            push[n] = 1'b0;
            pop[n]  = 1'b0;
            for (int s = 0; s < 2; s++) begin
                if (sel[s].kind == RK_DATA && sel[s].idx == 4'(n)) begin
                    if (p_wr[s] && send_ok[s][n]) push[n] = 1'b1;
                    if (p_rd[s] && recv_ok[s][n]) pop[n]  = 1'b1;
                end
            end
            din[n] = a2b[n] ? p_wdata[0] : p_wdata[1];
            for (int s = 0; s < 2; s++) begin
                set_rx[s][n] = push[n] && !full[n]  && recv_ok[s][n];
                set_tx[s][n] = pop[n]  && !empty[n] && send_ok[s][n];
            end
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push[n]),
            .pop   (pop[n]),
            .din   (din[n]),
            .head  (head[n]),
            .count (count[n]),
            .full  (full[n]),
            .empty (empty[n])
        );

        AST_RX_RAISE_B: assert property (@(posedge clk) disable iff (rst)
            (push[n] && !full[n] && a2b[n]) |=> stat[1][2*n]);     // R7
        AST_RX_RAISE_A: assert property (@(posedge clk) disable iff (rst)
            (push[n] && !full[n] && b2a[n]) |=> stat[0][2*n]);     // R7
        AST_WRONG_SIDE: assert property (@(posedge clk) disable iff (rst)
            (empty[n] && !push[n]) |=> empty[n]);                  // R6
    end

    // ---------------- interrupt banks ----------------
    for (genvar s = 0; s < 2; s++) begin : g_side
        mbox_irq_side #(.NCH(NCH), .DW(DW)) u_irq (
            .clk     (clk),
            .rst     (rst),
            .en_wr   (p_wr[s] && sel[s].kind == RK_OWN_EN),
            .st_clr  (p_wr[s] && sel[s].kind == RK_OWN_ST),
            .wdata   (p_wdata[s]),
            .set_rx  (set_rx[s]),
            .set_tx  (set_tx[s]),
            .rx_busy (~empty),
            .en      (en[s]),
            .stat    (stat[s]),
            .irq     (irq[s])
        );
    end

    // ---------------- read multiplexers ----------------
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            p_rdata[s] = '0;
            case (sel[s].kind)
                RK_CTRL: begin
                    if (sel[s].idx < 4'(CTW)) begin
                        for (int n = 0; n < NCH; n++) begin
                            if (sel[s].idx == 4'(n / 4)) begin
                                p_rdata[s][rx_bit(n)] = (s == 0) ? dir_q[n].rx_a : dir_q[n].tx_a;
                                p_rdata[s][tx_bit(n)] = (s == 0) ? dir_q[n].tx_a : dir_q[n].rx_a;
                            end
                        end
                    end
                end
                RK_REM_EN: p_rdata[s][SW-1:0] = en[1-s];
                RK_REM_ST: p_rdata[s][SW-1:0] = stat[1-s];
                RK_OWN_EN: p_rdata[s][SW-1:0] = en[s];
                RK_OWN_ST: p_rdata[s][SW-1:0] = stat[s];
                RK_FULL: begin
                    for (int n = 0; n < NCH; n++)
                        if (sel[s].idx == 4'(n)) p_rdata[s][0] = full[n];
                end
                RK_COUNT: begin
                    for (int n = 0; n < NCH; n++)
                        if (sel[s].idx == 4'(n)) p_rdata[s][CW-1:0] = count[n];
                end
                RK_DATA: begin
                    for (int n = 0; n < NCH; n++)
                        if (sel[s].idx == 4'(n) && recv_ok[s][n] && !empty[n])
                            p_rdata[s] = head[n];
                end
                default: p_rdata[s] = '0;
            endcase
        end
    end

    assign a_rdata = p_rdata[0];
    assign b_rdata = p_rdata[1];
    assign a_irq   = irq[0];
    assign b_irq   = irq[1];

    AST_CTRL_A_WINS: assert property (@(posedge clk) disable iff (rst)
        (a_wr && b_wr && sel[0].kind == RK_CTRL && sel[1].kind == RK_CTRL &&
         sel[0].idx == 4'd0 && sel[1].idx == 4'd0)
        |=> (dir_q[0].tx_a == $past(a_wdata[4]) && dir_q[0].rx_a == $past(a_wdata[0]))); // R12

endmodule

// File: tb/dual_mailbox_test.sv
module dual_mailbox_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  a_addr, b_addr;
    logic [31:0] a_wdata, b_wdata;
    logic        a_wr, a_rd, b_wr, b_rd;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    dual_mailbox uut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_wr(a_wr), .a_rd(a_rd),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_wr(b_wr), .b_rd(b_rd),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    typedef struct packed {
        logic        rd;     // 1 = read and compare, 0 = write
        logic        side;   // 0 = A, 1 = B
        logic [8:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 9'h000, 32'h0000_0010, 32'h0, 8'd2},   // R2 A: ch0 transmit
        '{1'b1, 1'b1, 9'h000, 32'h0, 32'h0000_0001, 8'd2},   // R2 mirrored view
        '{1'b1, 1'b0, 9'h000, 32'h0, 32'h0000_0010, 8'd2},
        '{1'b0, 1'b0, 9'h004, 32'h0000_0001, 32'h0, 8'd2},   // ch4 receive for A
        '{1'b1, 1'b1, 9'h004, 32'h0, 32'h0000_0010, 8'd2},
        '{1'b1, 1'b0, 9'h004, 32'h0, 32'h0000_0001, 8'd2},
        '{1'b0, 1'b1, 9'h060, 32'h0000_0001, 32'h0, 8'd11},  // R11 B enables ch0 rx
        '{1'b1, 1'b0, 9'h040, 32'h0, 32'h0000_0001, 8'd9},   // R9 remote enable
        '{1'b1, 1'b1, 9'h060, 32'h0, 32'h0000_0001, 8'd11},
        '{1'b0, 1'b0, 9'h180, 32'h1111_1111, 32'h0, 8'd3},   // R3 push 1
        '{1'b1, 1'b1, 9'h070, 32'h0, 32'h0000_0001, 8'd7},   // R7 rx bit raised
        '{1'b1, 1'b0, 9'h050, 32'h0, 32'h0000_0001, 8'd9},   // R9 remote status
        '{1'b1, 1'b1, 9'h140, 32'h0, 32'h0000_0001, 8'd4},   // R4 count
        '{1'b1, 1'b0, 9'h140, 32'h0, 32'h0000_0001, 8'd4},
        '{1'b0, 1'b0, 9'h180, 32'h2222_2222, 32'h0, 8'd3},
        '{1'b0, 1'b0, 9'h180, 32'h3333_3333, 32'h0, 8'd3},
        '{1'b0, 1'b0, 9'h180, 32'h4444_4444, 32'h0, 8'd3},
        '{1'b1, 1'b0, 9'h100, 32'h0, 32'h0000_0001, 8'd4},   // R4 full flag
        '{1'b1, 1'b1, 9'h140, 32'h0, 32'h0000_0004, 8'd4},
        '{1'b0, 1'b0, 9'h180, 32'h5555_5555, 32'h0, 8'd5},   // R5 write when full
        '{1'b1, 1'b1, 9'h140, 32'h0, 32'h0000_0004, 8'd5},
        '{1'b0, 1'b1, 9'h180, 32'h0000_DEAD, 32'h0, 8'd6},   // R6 receiver write
        '{1'b1, 1'b1, 9'h140, 32'h0, 32'h0000_0004, 8'd6},
        '{1'b1, 1'b0, 9'h180, 32'h0, 32'h0000_0000, 8'd6},   // R6 sender read
        '{1'b1, 1'b0, 9'h140, 32'h0, 32'h0000_0004, 8'd6},
        '{1'b0, 1'b1, 9'h070, 32'h0000_0001, 32'h0, 8'd8},   // R8 clear while busy
        '{1'b1, 1'b1, 9'h070, 32'h0, 32'h0000_0001, 8'd8},
        '{1'b1, 1'b1, 9'h180, 32'h0, 32'h1111_1111, 8'd3},   // R3 pop order
        '{1'b1, 1'b0, 9'h100, 32'h0, 32'h0000_0000, 8'd4},
        '{1'b1, 1'b0, 9'h070, 32'h0, 32'h0000_0002, 8'd10},  // R10 tx bit
        '{1'b1, 1'b1, 9'h180, 32'h0, 32'h2222_2222, 8'd3},
        '{1'b1, 1'b1, 9'h180, 32'h0, 32'h3333_3333, 8'd3},
        '{1'b1, 1'b1, 9'h180, 32'h0, 32'h4444_4444, 8'd5},   // R5 dropped word absent
        '{1'b1, 1'b1, 9'h140, 32'h0, 32'h0000_0000, 8'd3},
        '{1'b1, 1'b1, 9'h180, 32'h0, 32'h0000_0000, 8'd3},   // R3 empty read
        '{1'b0, 1'b1, 9'h070, 32'h0000_0001, 32'h0, 8'd8},
        '{1'b1, 1'b1, 9'h070, 32'h0, 32'h0000_0000, 8'd8},   // R8 clear when drained
        '{1'b1, 1'b0, 9'h050, 32'h0, 32'h0000_0000, 8'd9},   // R9 ack visible
        '{1'b0, 1'b0, 9'h070, 32'h0000_0002, 32'h0, 8'd8},
        '{1'b1, 1'b0, 9'h070, 32'h0, 32'h0000_0000, 8'd8},
        '{1'b0, 1'b1, 9'h190, 32'hABCD_0004, 32'h0, 8'd3},   // B -> A on ch4
        '{1'b1, 1'b0, 9'h070, 32'h0, 32'h0000_0100, 8'd7},
        '{1'b1, 1'b1, 9'h050, 32'h0, 32'h0000_0100, 8'd9},
        '{1'b1, 1'b0, 9'h150, 32'h0, 32'h0000_0001, 8'd4},
        '{1'b1, 1'b0, 9'h190, 32'h0, 32'hABCD_0004, 8'd3},
        '{1'b1, 1'b1, 9'h070, 32'h0, 32'h0000_0200, 8'd10},
        '{1'b0, 1'b0, 9'h184, 32'h0000_0001, 32'h0, 8'd6},   // R6 undirected ch1
        '{1'b1, 1'b0, 9'h144, 32'h0, 32'h0000_0000, 8'd6},
        '{1'b1, 1'b1, 9'h144, 32'h0, 32'h0000_0000, 8'd6},
        '{1'b0, 1'b1, 9'h050, 32'hFFFF_FFFF, 32'h0, 8'd9},   // R9 remote not writable
        '{1'b1, 1'b0, 9'h070, 32'h0, 32'h0000_0100, 8'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    endtask

    task automatic bus_op(input logic side, input logic rd, input logic [8:0] addr,
                          input logic [31:0] wd, output logic [31:0] rdv);
        @(negedge clk);
        if (side == 1'b0) begin
            a_addr = addr; a_wdata = wd; a_wr = !rd; a_rd = rd;
        end else begin
            b_addr = addr; b_wdata = wd; b_wr = !rd; b_rd = rd;
        end
        #1 rdv = side ? b_rdata : a_rdata;
        @(posedge clk);
        #1 idle();
    endtask

    task automatic rd_chk(input logic side, input logic [8:0] addr,
                          input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus_op(side, 1'b1, addr, 32'h0, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic side, input logic [8:0] addr, input logic [31:0] wd);
        logic [31:0] v;
        bus_op(side, 1'b0, addr, wd, v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst = 1; a_addr = 0; b_addr = 0; a_wdata = 0; b_wdata = 0; idle();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        @(negedge clk);
        check("R1 a_irq", {31'b0, a_irq}, 32'h0);
        check("R1 b_irq", {31'b0, b_irq}, 32'h0);
        rd_chk(1'b0, 9'h000, 32'h0, "R1 ctrl");
        rd_chk(1'b1, 9'h070, 32'h0, "R1 status");

        // table walk
        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].side, VEC[i].rd, VEC[i].addr, VEC[i].wd, v);
            if (VEC[i].rd) check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].exp);
        end

        // R11 interrupt lines
        @(negedge clk);
        check("R11 a_irq idle", {31'b0, a_irq}, 32'h0);
        check("R11 b_irq idle", {31'b0, b_irq}, 32'h0);
        wr(1'b0, 9'h060, 32'h0000_0100);
        check("R11 a_irq enabled", {31'b0, a_irq}, 32'h1);
        wr(1'b0, 9'h070, 32'h0000_0100);
        check("R8 R11 a_irq cleared", {31'b0, a_irq}, 32'h0);
        wr(1'b0, 9'h180, 32'h0000_0077);
        check("R7 R11 b_irq raised", {31'b0, b_irq}, 32'h1);

        // R12 simultaneous control writes
        @(negedge clk);
        a_addr = 9'h000; a_wdata = 32'h0000_1000; a_wr = 1;
        b_addr = 9'h000; b_wdata = 32'h0000_0010; b_wr = 1;
        @(posedge clk);
        #1 idle();
        rd_chk(1'b0, 9'h000, 32'h0000_1000, "R12 A view");
        rd_chk(1'b1, 9'h000, 32'h0000_0100, "R12 B view");

        // R1 reset mid-run
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 b_irq after reset", {31'b0, b_irq}, 32'h0);
        rd_chk(1'b1, 9'h140, 32'h0, "R1 count");
        rd_chk(1'b0, 9'h000, 32'h0, "R1 ctrl after reset");
        rd_chk(1'b1, 9'h060, 32'h0, "R1 enable");

        finish_run();
    end

endmodule